// File: doc/BRIEF.md
# Spectrum Magnitude Normaliser

This block takes complex spectrum bins one at a time, each tagged with its bin index, and returns one normalised amplitude per bin. For every bin it forms the sum of the squared real and imaginary parts at full double width. It then extracts the integer square root one result bit per cycle and scales the root for a single-sided amplitude spectrum. The scaling depends on the bin: the zero-frequency bin is divided by the transform length N, and every other bin is multiplied by 2/N.

N is a parameter and must be a power of two, so both scale factors reduce to right shifts of the root. The block takes one bin at a time. `in_ready` is high while it is idle. A bin is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result appears a fixed number of cycles later as a one-cycle `out_valid` pulse, together with the bin index that came in with it. Results therefore leave in the order the bins arrived. Inputs are signed two's complement and the output is an unsigned integer, truncated toward zero.

Top module: `mag_norm`

## Requirements
- R1: While reset (`rst_n` = 0) is asserted and in the cycle after it is released, `out_valid` is 0 and `in_ready` is 1. A bin that is in progress when reset arrives produces no output afterwards.
- R2: The unscaled magnitude is floor(sqrt(re*re + im*im)). `in_re` and `in_im` are signed two's complement, and the most negative value is included.
- R3: For a bin whose index is 0, `out_mag` = floor(magnitude / N), which is the magnitude shifted right by log2(N).
- R4: For any bin whose index is not 0, `out_mag` = floor(2 * magnitude / N), which is the magnitude shifted right by log2(N) - 1.
- R5: `out_bin` equals the `in_bin` value that was captured with the bin being reported.
- R6: `out_valid` is high for exactly one cycle per accepted bin. It is high in the cycle after the (DW+1)-th rising edge that follows the accepting edge.
- R7: `in_ready` is 0 from the edge that accepts a bin until the edge that raises `out_valid`. `in_valid` and input data seen while `in_ready` is 0 are ignored: they change neither the pending result nor the number of results.
- R8: Bins presented one after another each produce their own result, in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A bin is presented |
| in_ready | output | 1 | Block is idle and will accept a bin on this edge |
| in_re | input | DW | Real part, signed |
| in_im | input | DW | Imaginary part, signed |
| in_bin | input | log2(N) | Bin index of the presented bin |
| out_valid | output | 1 | One-cycle strobe: result available |
| out_bin | output | log2(N) | Bin index of the result |
| out_mag | output | DW | Normalised magnitude, unsigned |

## Verification
The main function is driven with purely real inputs, purely imaginary inputs and mixed-sign pairs, including the most negative input on both axes. These show whether the sign handling and the double-width sum are right. Magnitudes that sit just below and just above a scale step (1023 and 1024 on bin 0, 511 and 512 on a non-zero bin) separate the divide-by-N shift from the divide-by-N/2 shift and catch an off-by-one in the shift amount. Pythagorean pairs give exact roots, and non-square sums check that the root is truncated and never rounded. Noise on the input during a computation and a reset part-way through one show whether the acceptance gate works and whether a stale result can leak out.

// File: rtl/mag_norm_pkg.sv
package mag_norm_pkg;

  typedef enum logic {
    MN_IDLE = 1'b0,
    MN_BUSY = 1'b1
  } mn_state_e;

  // Right-shift that turns a root into its single-sided amplitude:
  // divide by N for the zero bin, by N/2 for the others.
  function automatic int unsigned mn_shift(input logic is_dc, input int unsigned log2n);
    return is_dc ? log2n : log2n - 1;
  endfunction

endpackage

// File: rtl/mn_sq_sum.sv
module mn_sq_sum #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   re,
  input  logic [DW-1:0]   im,
  output logic [2*DW-1:0] sum
);
  localparam int PW = 2 * DW;

  function automatic logic [PW-1:0] square_of(input logic [DW-1:0] v);
    logic signed [PW-1:0] ext;
    logic signed [PW-1:0] prod;
    ext  = {{DW{v[DW-1]}}, v};
    prod = ext * ext;
    return prod;
  endfunction

  // Each square is at most 2^(2DW-2), so the sum fits in 2*DW bits unsigned.
  function automatic logic [PW-1:0] power_of(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return square_of(a) + square_of(b);
  endfunction

  assign sum = power_of(re, im);

endmodule

// File: rtl/mn_isqrt.sv
module mn_isqrt #(
  parameter int RW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*RW-1:0] radicand,
  output logic            done,
  output logic [RW-1:0]   root,
  output logic [2*RW-1:0] rad_held
);
  localparam int RADW = 2 * RW;
  localparam int REMW = RW + 3;
  localparam int CW   = $clog2(RW + 1);

  logic [RADW-1:0] rad_sh;
  logic [REMW-1:0] rem;
  logic [CW-1:0]   steps_left;
  logic            busy;

  // One result bit: bring down the next two radicand bits and try to
  // subtract 4*root+1; the bit is 1 when the trial does not go negative.
  function automatic logic [REMW+RW-1:0] digit_step(
    input logic [REMW-1:0] r_in,
    input logic [RW-1:0]   q_in,
    input logic [1:0]      pair
  );
    logic [REMW-1:0] cand;
    logic [REMW-1:0] trial;
    cand  = {r_in[REMW-3:0], pair};
    trial = {1'b0, q_in, 2'b01};
    if (cand >= trial) return {cand - trial, q_in[RW-2:0], 1'b1};
    else               return {cand,         q_in[RW-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rad_sh     <= '0;
      rad_held   <= '0;
      rem        <= '0;
      root       <= '0;
      steps_left <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rad_sh     <= radicand;
        rad_held   <= radicand;
        rem        <= '0;
        root       <= '0;
        steps_left <= CW'(RW);
        busy       <= 1'b1;
      end else if (busy) begin
        {rem, root} <= digit_step(rem, root, rad_sh[RADW-1 -: 2]);
        rad_sh      <= rad_sh << 2;
        steps_left  <= steps_left - 1'b1;
        if (steps_left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mn_scale.sv
module mn_scale #(
  parameter int DW    = 16,
  parameter int LOG2N = 10
) (
  input  logic [DW-1:0] mag,
  input  logic          is_dc,
  output logic [DW-1:0] scaled
);
  import mag_norm_pkg::*;

  localparam int unsigned SH_DC = mn_shift(1'b1, LOG2N);
  localparam int unsigned SH_AC = mn_shift(1'b0, LOG2N);

  assign scaled = is_dc ? (mag >> SH_DC) : (mag >> SH_AC);

endmodule

// File: rtl/mag_norm.sv
module mag_norm #(
  parameter int N_PTS = 1024,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DW-1:0]            in_re,
  input  logic [DW-1:0]            in_im,
  input  logic [$clog2(N_PTS)-1:0] in_bin,
  output logic                     out_valid,
  output logic [$clog2(N_PTS)-1:0] out_bin,
  output logic [DW-1:0]            out_mag
);
  import mag_norm_pkg::*;

  localparam int LOG2N = $clog2(N_PTS);
  localparam int PW    = 2 * DW;

  mn_state_e        state;
  logic             accept;
  logic [LOG2N-1:0] bin_q;
  logic [PW-1:0]    power;
  logic             root_done;
  logic [DW-1:0]    root_val;
  logic [PW-1:0]    root_rad;
  logic [DW-1:0]    scaled;

  assign in_ready = (state == MN_IDLE);
  assign accept   = in_valid && in_ready;

  mn_sq_sum #(.DW(DW)) u_power (
    .re  (in_re),
    .im  (in_im),
    .sum (power)
  );

  mn_isqrt #(.RW(DW)) u_root (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .radicand (power),
    .done     (root_done),
    .root     (root_val),
    .rad_held (root_rad)
  );

  mn_scale #(.DW(DW), .LOG2N(LOG2N)) u_scale (
    .mag    (root_val),
    .is_dc  (bin_q == '0),
    .scaled (scaled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= MN_IDLE;
      bin_q     <= '0;
      out_valid <= 1'b0;
      out_bin   <= '0;
      out_mag   <= '0;
    end else begin
      out_valid <= root_done;
      if (accept) begin
        state <= MN_BUSY;
        bin_q <= in_bin;
      end else if (root_done) begin
        state   <= MN_IDLE;
        out_bin <= bin_q;
        out_mag <= scaled;
      end
    end
  end

endmodule

// File: rtl/mag_norm_chk.sv
module mag_norm_chk #(
  parameter int DW    = 16,
  parameter int LOG2N = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [LOG2N-1:0] out_bin,
  input logic [DW-1:0]    out_mag,
  input logic             sq_done,
  input logic [DW-1:0]    sq_root,
  input logic [2*DW-1:0]  sq_rad
);
  localparam int XW = 2 * DW + 2;
  localparam logic [DW-1:0] DC_MAX = {DW{1'b1}} >> LOG2N;

  logic [XW-1:0] root_x;
  logic [XW-1:0] root_x1;
  logic [XW-1:0] rad_x;
  assign root_x  = XW'(sq_root);
  assign root_x1 = XW'(sq_root) + XW'(1);
  assign rad_x   = XW'(sq_rad);

  AST_ROOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    sq_done |-> ((root_x * root_x <= rad_x) && (root_x1 * root_x1 > rad_x))); // R2

  AST_DC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_bin == '0)) |-> (out_mag <= DC_MAX)); // R3

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R6

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R7

  AST_READY_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready); // R7

endmodule

bind mag_norm mag_norm_chk #(.DW(DW), .LOG2N(LOG2N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_bin   (out_bin),
  .out_mag   (out_mag),
  .sq_done   (root_done),
  .sq_root   (root_val),
  .sq_rad    (root_rad)
);

// File: tb/sim_mag_norm.sv
`timescale 1ns/1ps
module sim_mag_norm;
  localparam int N_PTS = 1024;
  localparam int DW    = 16;
  localparam int BW    = 10;
  localparam int NVEC  = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_re = '0;
  logic [DW-1:0] in_im = '0;
  logic [BW-1:0] in_bin = '0;
  logic          out_valid;
  logic [BW-1:0] out_bin;
  logic [DW-1:0] out_mag;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  mag_norm #(.N_PTS(N_PTS), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_re(in_re), .in_im(in_im), .in_bin(in_bin),
    .out_valid(out_valid), .out_bin(out_bin), .out_mag(out_mag)
  );

  // {re, im, bin}
  localparam logic [41:0] VECS [NVEC] = '{
    {16'h0000, 16'h0000, 10'd0},    // zero input
    {16'h03FF, 16'h0000, 10'd0},    // 1023 on DC: just below one step
    {16'h0400, 16'h0000, 10'd0},    // 1024 on DC: exactly one step
    {16'h8000, 16'h0000, 10'd0},    // most negative real on DC
    {16'h8000, 16'h8000, 10'd5},    // most negative on both axes
    {16'h0BB8, 16'h0FA0, 10'd1},    // 3000,4000 -> exact 5000
    {16'h0BB8, 16'h0FA0, 10'd0},    // same pair on DC
    {16'h7FFF, 16'h7FFF, 10'd1023}, // largest positive, last bin
    {16'h01FF, 16'h0000, 10'd3},    // 511 on AC: just below one step
    {16'h0200, 16'h0000, 10'd3},    // 512 on AC: exactly one step
    {16'h0000, 16'hB1E0, 10'd7},    // purely imaginary, negative
    {16'h3039, 16'hE57B, 10'd2},    // mixed sign, non-square sum
    {16'hFFFF, 16'hFFFF, 10'd9}     // tiny magnitude
  };

  function automatic longint ref_root(input longint s);
    longint r = 0;
    for (int b = 17; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= s) r = t;
    end
    return r;
  endfunction

  function automatic longint ref_out(input int re, input int im, input int bin);
    longint m = ref_root(longint'(re) * re + longint'(im) * im);
    return (bin == 0) ? (m / N_PTS) : ((2 * m) / N_PTS);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Present one bin, follow it cycle by cycle, check timing and value.
  task automatic run_bin(input logic [15:0] re, input logic [15:0] im,
                         input logic [9:0] bin, input bit noise, input string req);
    longint exp = ref_out($signed(re), $signed(im), int'(bin));
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_re = re; in_im = im; in_bin = bin; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      in_re = 16'h1234; in_im = 16'h7000; in_bin = 10'd0;
    end else in_valid = 1'b0;
    for (int k = 1; k <= DW + 1; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == DW) in_valid = 1'b0;
      if (k <= DW) begin
        if (out_valid !== 1'b0 || in_ready !== 1'b0) begin
          chk(1'b0, "R6/R7 early", {out_valid, in_ready}, 0);
          return;
        end
      end
    end
    chk(out_valid === 1'b1, "R6 valid at latency", out_valid, 1);
    chk(out_mag == exp[DW-1:0], req, out_mag, exp);
    chk(out_bin == bin, "R5 bin index", out_bin, bin);
    @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R6 single pulse", out_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready === 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1 after release", {out_valid, in_ready}, 1);

    // Table walk: R2 magnitude, R3 DC scale, R4 AC scale, R8 order
    for (int i = 0; i < NVEC; i++) begin
      logic [41:0] v = VECS[i];
      run_bin(v[41:26], v[25:10], v[9:0], 1'b0,
              (v[9:0] == 0) ? "R2/R3 DC magnitude" : "R2/R4 AC magnitude");
    end

    // R7: input held with other data during the computation is ignored
    run_bin(16'h0BB8, 16'h0FA0, 10'd4, 1'b1, "R7 noise ignored");
    for (int k = 0; k < DW + 4; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (out_valid !== 1'b0) chk(1'b0, "R7 extra result", out_valid, 0);
    end
    chk(out_valid === 1'b0, "R7 no extra result", out_valid, 0);

    // R8: back-to-back bins keep their order and indices
    run_bin(16'h0400, 16'h0000, 10'd11, 1'b0, "R8 first of pair");
    run_bin(16'h0800, 16'h0000, 10'd12, 1'b0, "R8 second of pair");

    // R1: reset part-way through a computation leaves no stale result
    @(negedge clk);
    in_re = 16'h4000; in_im = 16'h0000; in_bin = 10'd6; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 reset mid-run", {out_valid, in_ready}, 1);
    rst_n = 1'b1;
    for (int k = 0; k < DW + 4; k++) begin
      @(negedge clk);
      if (out_valid !== 1'b0) chk(1'b0, "R1 stale result", out_valid, 0);
    end
    chk(in_ready === 1'b1, "R1 idle after mid-run reset", in_ready, 1);

    // block still works after that reset
    run_bin(16'h4000, 16'h0000, 10'd0, 1'b0, "R3 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule